// File: doc/BRIEF.md
# Power-Down and Oscillator Enable Controller

This block decides which clock sources of a small microcontroller are switched on. Software programs two registers through a simple write/read port. The power register holds one enable for each oscillator and two qualifying bits for power-down. The PLL register holds one bit that picks the PLL reference. The block drives the enable line of each oscillator and the PLL reference select, and it reports whether the chip is currently powered down.

Power-down starts only when the CPU signals a wait-for-interrupt (WFI) event while both qualifying bits are set. While powered down, the crystal enable and the high-speed RC enable are held low, whatever their register bits say. The low-speed RC oscillator keeps running so that it can clock the wake-up logic. A wake-up request returns the block to the run state, and the high-speed enables then follow their register bits again. The registers keep their contents throughout.

Top module: `pwr_osc_ctrl`

## Requirements
- R1: After reset, the power register reads 0x0000000C: crystal enable 0, high-speed RC enable 1, low-speed RC enable 1, and both power-down bits 0. The PLL register reads 0, the power-down flag is 0, and the PLL reference select is 0.
- R2: Register select 0 addresses the power register and select 1 addresses the PLL register. The power register implements bit 0 (crystal enable), bit 2 (high-speed RC enable), bit 3 (low-speed RC enable), bit 7 (power-down enable) and bit 8 (wait-for-CPU). Every other bit reads 0. A write takes effect on the next clock edge, and a read returns the addressed register combinationally.
- R3: Bit 19 is the only implemented bit of the PLL register. The PLL reference select output equals this bit: 0 selects the crystal and 1 selects the high-speed RC oscillator.
- R4: A WFI pulse sampled while power register bits 7 and 8 are both 1 sets the power-down flag on that same clock edge. The bit values used are the ones held before any write on that edge.
- R5: A WFI pulse sampled while bit 7 or bit 8 is 0 is ignored, and the power-down flag stays 0.
- R6: While the power-down flag is 1, the crystal enable output and the high-speed RC enable output are 0.
- R7: The low-speed RC enable output equals power register bit 3 at all times, in both run and power-down.
- R8: A wake-up request sampled while powered down clears the power-down flag on that clock edge, and the high-speed enables return to their register values at the same time.
- R9: A wake-up request that is already high when an accepted WFI pulse is sampled still produces exactly one cycle with the power-down flag set.
- R10: Register contents are kept through power-down, and writes made during power-down take effect normally.
- R11: In the run state, the crystal and high-speed RC enable outputs equal register bits 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 1 | Register select: 0 power, 1 PLL |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| wfi_pulse | input | 1 | WFI event from the CPU, one cycle |
| wake_req | input | 1 | Wake-up interrupt request |
| xtal_en | output | 1 | Crystal oscillator enable |
| hirc_en | output | 1 | High-speed RC oscillator enable |
| lirc_en | output | 1 | Low-speed RC oscillator enable |
| pd_active | output | 1 | Power-down flag |
| pll_ref_sel | output | 1 | PLL reference select |

## Verification
The assertions assume that the WFI and wake-up inputs are synchronous to the clock and hold a stable value at each rising edge. They also assume that a wake-up request stays high for as long as it is meant to count. The bench changes every input one nanosecond after a rising edge and returns the WFI pulse to 0 after one cycle. It holds a wake-up request for one or more cycles, sometimes starting before the WFI pulse to cover the overlap case.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_PD  = 1'b1
  } pwr_state_e;

  // Masks an oscillator enable with the power-down condition.
  function automatic logic gate_hs(input logic reg_en, input logic pd);
    return reg_en & ~pd;
  endfunction

  // Power-down entry qualification.
  function automatic logic entry_ok(input logic wfi, input logic pd_en,
                                    input logic wait_cpu);
    return wfi & pd_en & wait_cpu;
  endfunction

  // Builds a one-hot mask for a bit position.
  function automatic logic [31:0] bit_mask(input int unsigned pos);
    return 32'd1 << pos;
  endfunction

endpackage

// File: rtl/pwr_regfile.sv
module pwr_regfile #(
  parameter int DATA_W   = 32,
  parameter int XTAL_POS = 0,
  parameter int HIRC_POS = 2,
  parameter int LIRC_POS = 3,
  parameter int PDEN_POS = 7,
  parameter int WAIT_POS = 8,
  parameter int PLL_POS  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              xtal_bit,
  output logic              hirc_bit,
  output logic              lirc_bit,
  output logic              pden_bit,
  output logic              wait_bit,
  output logic              pll_bit
);
  import pwr_pkg::*;

  localparam logic [DATA_W-1:0] PWR_MASK =
    DATA_W'(bit_mask(XTAL_POS) | bit_mask(HIRC_POS) | bit_mask(LIRC_POS) |
            bit_mask(PDEN_POS) | bit_mask(WAIT_POS));
  localparam logic [DATA_W-1:0] PLL_MASK = DATA_W'(bit_mask(PLL_POS));
  localparam logic [DATA_W-1:0] PWR_RST  =
    DATA_W'(bit_mask(HIRC_POS) | bit_mask(LIRC_POS));

  logic [DATA_W-1:0] pwr_q;
  logic [DATA_W-1:0] pll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= PWR_RST;
      pll_q <= '0;
    end else if (wr) begin
      if (sel) pll_q <= wdata & PLL_MASK;
      else     pwr_q <= wdata & PWR_MASK;
    end
  end

  always_comb rdata = sel ? pll_q : pwr_q;

  assign xtal_bit = pwr_q[XTAL_POS];
  assign hirc_bit = pwr_q[HIRC_POS];
  assign lirc_bit = pwr_q[LIRC_POS];
  assign pden_bit = pwr_q[PDEN_POS];
  assign wait_bit = pwr_q[WAIT_POS];
  assign pll_bit  = pll_q[PLL_POS];

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic wfi,
  input  logic wake,
  input  logic pd_en,
  input  logic wait_cpu,
  output logic pd,
  output logic pd_enter,
  output logic pd_exit
);
  import pwr_pkg::*;

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    pd_enter = 1'b0;
    pd_exit  = 1'b0;
    unique case (state_q)
      ST_RUN: if (entry_ok(wfi, pd_en, wait_cpu)) begin
        state_d  = ST_PD;
        pd_enter = 1'b1;
      end
      ST_PD: if (wake) begin
        state_d = ST_RUN;
        pd_exit = 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign pd = (state_q == ST_PD);

endmodule

// File: rtl/pwr_gate.sv
module pwr_gate #(
  parameter int N_HS = 2
) (
  input  logic            pd,
  input  logic [N_HS-1:0] hs_bits,
  input  logic            ls_bit,
  output logic [N_HS-1:0] hs_en,
  output logic            ls_en
);
  import pwr_pkg::*;

  for (genvar g = 0; g < N_HS; g++) begin : g_hs
    assign hs_en[g] = gate_hs(hs_bits[g], pd);
  end

  assign ls_en = ls_bit;

endmodule

// File: rtl/pwr_osc_ctrl.sv
module pwr_osc_ctrl #(
  parameter int DATA_W   = 32,
  parameter int XTAL_POS = 0,
  parameter int HIRC_POS = 2,
  parameter int LIRC_POS = 3,
  parameter int PDEN_POS = 7,
  parameter int WAIT_POS = 8,
  parameter int PLL_POS  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wfi_pulse,
  input  logic              wake_req,
  output logic              xtal_en,
  output logic              hirc_en,
  output logic              lirc_en,
  output logic              pd_active,
  output logic              pll_ref_sel
);
  localparam int N_HS = 2;

  logic xtal_bit, hirc_bit, lirc_bit, pden_bit, wait_bit, pll_bit;
  logic pd, pd_enter, pd_exit;
  logic [N_HS-1:0] hs_en;

  pwr_regfile #(
    .DATA_W(DATA_W), .XTAL_POS(XTAL_POS), .HIRC_POS(HIRC_POS),
    .LIRC_POS(LIRC_POS), .PDEN_POS(PDEN_POS), .WAIT_POS(WAIT_POS),
    .PLL_POS(PLL_POS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .xtal_bit(xtal_bit), .hirc_bit(hirc_bit), .lirc_bit(lirc_bit),
    .pden_bit(pden_bit), .wait_bit(wait_bit), .pll_bit(pll_bit)
  );

  pwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wfi(wfi_pulse), .wake(wake_req),
    .pd_en(pden_bit), .wait_cpu(wait_bit),
    .pd(pd), .pd_enter(pd_enter), .pd_exit(pd_exit)
  );

  pwr_gate #(.N_HS(N_HS)) u_gate (
    .pd(pd), .hs_bits({hirc_bit, xtal_bit}), .ls_bit(lirc_bit),
    .hs_en(hs_en), .ls_en(lirc_en)
  );

  assign xtal_en     = hs_en[0];
  assign hirc_en     = hs_en[1];
  assign pd_active   = pd;
  assign pll_ref_sel = pll_bit;

endmodule

// File: rtl/pwr_osc_ctrl_chk.sv
module pwr_osc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wfi_pulse,
  input logic wake_req,
  input logic pden_bit,
  input logic wait_bit,
  input logic xtal_bit,
  input logic hirc_bit,
  input logic lirc_bit,
  input logic pll_bit,
  input logic pd_active,
  input logic pd_enter,
  input logic pd_exit,
  input logic xtal_en,
  input logic hirc_en,
  input logic lirc_en,
  input logic pll_ref_sel
);
  assert_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_active && wfi_pulse && pden_bit && wait_bit) |=> pd_active);

  assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_active && !(wfi_pulse && pden_bit && wait_bit)) |=> !pd_active);

  assert_hs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (!xtal_en && !hirc_en));

  assert_lirc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lirc_en == lirc_bit);

  assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && wake_req) |=> !pd_active);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && !wake_req) |=> pd_active);

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_enter && pd_exit));

  assert_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_active |-> (xtal_en == xtal_bit && hirc_en == hirc_bit));

  assert_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ref_sel == pll_bit);
endmodule

bind pwr_osc_ctrl pwr_osc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wfi_pulse(wfi_pulse), .wake_req(wake_req),
  .pden_bit(pden_bit), .wait_bit(wait_bit), .xtal_bit(xtal_bit),
  .hirc_bit(hirc_bit), .lirc_bit(lirc_bit), .pll_bit(pll_bit),
  .pd_active(pd_active), .pd_enter(pd_enter), .pd_exit(pd_exit),
  .xtal_en(xtal_en), .hirc_en(hirc_en), .lirc_en(lirc_en),
  .pll_ref_sel(pll_ref_sel)
);

// File: tb/tb_pwr_osc_ctrl.sv
module tb_pwr_osc_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0, wfi_pulse = 1'b0, wake_req = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic xtal_en, hirc_en, lirc_en, pd_active, pll_ref_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_osc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wfi_pulse(wfi_pulse),
    .wake_req(wake_req), .xtal_en(xtal_en), .hirc_en(hirc_en),
    .lirc_en(lirc_en), .pd_active(pd_active), .pll_ref_sel(pll_ref_sel)
  );

  // Reference model: values held as plain integers.
  int m_pwr = 12;
  int m_pll = 0;
  int m_pd  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 12; m_pll = 0; m_pd = 0;
    end else begin
      int nxt;
      if (m_pd != 0) nxt = wake_req ? 0 : 1;
      else nxt = (wfi_pulse && ((m_pwr >> 7) % 2 == 1) && ((m_pwr >> 8) % 2 == 1)) ? 1 : 0;
      if (reg_wr) begin
        if (reg_sel) m_pll = int'(reg_wdata) & 32'h0008_0000;
        else         m_pwr = int'(reg_wdata) & 32'h0000_018D;
      end
      m_pd = nxt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int run;
      run = (m_pd == 0);
      chk(run ? "R11 xtal" : "R6 xtal", int'(xtal_en), run ? (m_pwr & 1) : 0);
      chk(run ? "R11 hirc" : "R6 hirc", int'(hirc_en), run ? ((m_pwr >> 2) & 1) : 0);
      chk("R7 lirc", int'(lirc_en), (m_pwr >> 3) & 1);
      chk("R4 pd", int'(pd_active), m_pd);
      chk("R3 pll", int'(pll_ref_sel), (m_pll >> 19) & 1);
      chk("R2 rdata", int'(reg_rdata), reg_sel ? m_pll : m_pwr);
    end
  end

  task automatic drive(input logic wr, input logic sel, input logic [31:0] d,
                       input logic wfi, input logic wk);
    @(posedge clk); #1;
    reg_wr = wr; reg_sel = sel; reg_wdata = d; wfi_pulse = wfi; wake_req = wk;
  endtask

  task automatic idle(input int n, input logic wk);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, 1'b0, wk);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #7 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwr reset", int'(reg_rdata), 32'hC);
    chk("R1 pd reset", int'(pd_active), 0);
    chk("R1 xtal reset", int'(xtal_en), 0);
    chk("R1 hirc reset", int'(hirc_en), 1);
    drive(1'b0, 1'b1, '0, 1'b0, 1'b0); @(negedge clk);
    chk("R1 pll reset", int'(reg_rdata), 0);

    // R2: unimplemented bits read 0.
    drive(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R2 pwr mask", int'(reg_rdata), 32'h18D);
    // R3: PLL select bit.
    drive(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R3 pll sel", int'(pll_ref_sel), 1);
    drive(1'b1, 1'b1, 32'h0, 1'b0, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R3 pll clr", int'(pll_ref_sel), 0);

    // R5: only bit 7 set, then only bit 8 set.
    drive(1'b1, 1'b0, 32'h08D, 1'b0, 1'b0);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R5 ignored pden only", int'(pd_active), 0);
    drive(1'b1, 1'b0, 32'h10D, 1'b0, 1'b0);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R5 ignored wait only", int'(pd_active), 0);
    chk("R5 xtal still on", int'(xtal_en), 1);

    // R4/R6: enter power-down.
    drive(1'b1, 1'b0, 32'h18D, 1'b0, 1'b0);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R4 entered", int'(pd_active), 1);
    chk("R6 xtal off", int'(xtal_en), 0);
    chk("R6 hirc off", int'(hirc_en), 0);
    idle(3, 1'b0); @(negedge clk);
    chk("R10 kept in pd", int'(reg_rdata), 32'h18D);
    // R7/R10: write in power-down clears low-speed enable.
    drive(1'b1, 1'b0, 32'h185, 1'b0, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R7 lirc off in pd", int'(lirc_en), 0);
    chk("R10 write in pd", int'(pd_active), 1);
    // R8: wake.
    drive(1'b0, 1'b0, '0, 1'b0, 1'b1); idle(1, 1'b0); @(negedge clk);
    chk("R8 exited", int'(pd_active), 0);
    chk("R8 xtal back", int'(xtal_en), 1);
    chk("R10 kept after pd", int'(reg_rdata), 32'h185);

    // R9: wake already high at WFI.
    drive(1'b1, 1'b0, 32'h18D, 1'b0, 1'b1);
    drive(1'b0, 1'b0, '0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, '0, 1'b0, 1'b1); @(negedge clk);
    chk("R9 one cycle pd", int'(pd_active), 1);
    idle(1, 1'b1); @(negedge clk);
    chk("R9 exit after one", int'(pd_active), 0);

    // R4: write on the entry edge uses the old bits.
    drive(1'b1, 1'b0, 32'h00D, 1'b1, 1'b0); idle(1, 1'b0); @(negedge clk);
    chk("R4 old bits used", int'(pd_active), 1);
    idle(2, 1'b0);
    drive(1'b0, 1'b0, '0, 1'b0, 1'b1); idle(1, 1'b0); @(negedge clk);
    chk("R8 exit again", int'(pd_active), 0);
    // WFI with bits now cleared.
    drive(1'b0, 1'b0, '0, 1'b1, 1'b0); idle(2, 1'b0); @(negedge clk);
    chk("R5 ignored cleared", int'(pd_active), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule